// File: doc/BRIEF.md
# Programmable Serial Clock Divider

This block produces a slower serial-interface clock from one functional clock. A 4-bit rate code selects the ratio. Codes 2 through 10 divide by their own value. Code 0, code 1 and every code above 10 fall back to divide-by-1. In that mode the functional clock passes straight through to the output.

Beside the divided clock, the block drives a single-cycle tick that marks the first functional cycle of every divided period. Logic in the functional domain can use the tick as a clock enable instead of the divided clock. A status output shows the divisor that is currently in force. The rate code may change at any time. The new value is taken only when the running period ends, so no high or low phase is ever cut short.

Top module: `serial_clk_divider`

## Requirements
- R1: Rate codes 0 and 1 select divide-by-1, and `eff_div` then reads 1.
- R2: Rate codes 2 through 10 select a division ratio equal to the code, and `eff_div` reads that code. The top value is the parameter `MAX_DIV`, which defaults to 10.
- R3: Rate codes 11 through 15 select divide-by-1, and `eff_div` reads 1.
- R4: For an even ratio N, `div_clk` is high for N/2 functional cycles and then low for N/2 cycles. The high phase starts the period.
- R5: For an odd ratio N, `div_clk` is high for (N+1)/2 functional cycles and then low for (N-1)/2 cycles.
- R6: `div_tick` is high for exactly one functional cycle, the first cycle of each divided period, and consecutive ticks are N cycles apart.
- R7: In divide-by-1 mode, `div_clk` follows `clk` (high while `clk` is high, low while it is low) and `div_tick` stays high on every cycle.
- R8: A rate code is sampled only on the last cycle of a divided period. A change made mid-period leaves the running period at its full old length, and `eff_div` changes at the next period start.
- R9: `rst` is synchronous and active-high. While it is applied, `div_clk` and `div_tick` are low and `eff_div` reads 0. The first period, at the current rate code, starts on the first clock edge after `rst` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock, the only clock source |
| rst | input | 1 | Synchronous active-high reset |
| rate_code | input | 4 | Requested rate code |
| div_clk | output | 1 | Divided serial-interface clock |
| div_tick | output | 1 | One-cycle marker at the start of each divided period |
| eff_div | output | 4 | Divisor in force for the running period (0 in reset) |

## Verification
All sixteen rate codes are applied in turn, and `eff_div` is read at the first period start after each change. This separates the pass-through codes at both ends from the codes that divide.

Full periods are traced sample by sample for even ratios (2, 4, 10) and odd ratios (3, 5, 9). This shows whether the extra cycle of an odd ratio lands in the high phase, and whether the tick repeats at exactly N cycles. For divide-by-1, the output is sampled in both halves of the functional clock to tell real pass-through from a held level.

A rate change made in the middle of a divide-by-8 period, and a reset applied mid-run, show whether the running period is protected and whether the outputs return to idle.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    localparam int SD_CODE_W  = 4;
    localparam int SD_MIN_DIV = 2;

    typedef logic [SD_CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    typedef struct packed {
        logic  run;
        code_t div;
        code_t cnt;
    } period_state_t;

    // Map a rate code onto the ratio it selects
    function automatic code_t decode_rate(input code_t code, input int max_div);
        if (int'(code) >= SD_MIN_DIV && int'(code) <= max_div)
            return code;
        return code_t'(1);
    endfunction

    // Length of the high phase for a ratio n (odd ratios favour high)
    function automatic code_t high_len(input code_t n);
        logic [SD_CODE_W:0] wide;
        wide = {1'b0, n} + 1'b1;
        return code_t'(wide >> 1);
    endfunction

endpackage

// File: rtl/sdiv_rate_decode.sv
module sdiv_rate_decode
    import sdiv_pkg::*;
#(
    parameter int MAX_DIV = 10
) (
    input  code_t req_code,
    output code_t req_div
);

    always_comb begin
        req_div = decode_rate(req_code, MAX_DIV);
    end

    // R2
    always_comb begin
        range_chk: assert (req_div >= code_t'(1) && int'(req_div) <= MAX_DIV);
    end

endmodule

// File: rtl/sdiv_period_ctr.sv
module sdiv_period_ctr
    import sdiv_pkg::*;
#(
    parameter int MAX_DIV = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  code_t         req_div,
    output period_state_t cur,
    output period_state_t nxt,
    output logic          start_nxt
);

    always_comb begin
        start_nxt = !cur.run || (cur.cnt == cur.div - 1'b1);
        nxt       = cur;
        nxt.run   = 1'b1;
        if (start_nxt) begin
            nxt.div = req_div;
            nxt.cnt = '0;
        end else begin
            nxt.cnt = cur.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    // R8
    rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur.run && cur.cnt != cur.div - 1'b1) |=> $stable(cur.div));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cur.run |-> (cur.cnt < cur.div && int'(cur.div) <= MAX_DIV));

endmodule

// File: rtl/sdiv_phase_gen.sv
module sdiv_phase_gen
    import sdiv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  period_state_t nxt,
    input  logic          start_nxt,
    output phase_e        phase,
    output logic          tick_q,
    output logic          bypass_q
);

    logic hi;
    assign hi = (phase == PH_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            tick_q   <= 1'b0;
            bypass_q <= 1'b0;
        end else begin
            tick_q   <= start_nxt;
            bypass_q <= (nxt.div == code_t'(1));
            phase    <= (nxt.cnt < high_len(nxt.div)) ? PH_HIGH : PH_LOW;
        end
    end

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (phase == PH_IDLE && !tick_q && !bypass_q));

    // R6
    rise_with_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hi) |-> tick_q);

    // R7
    bypass_tick_chk: assert property (@(posedge clk) disable iff (rst)
        bypass_q |-> (tick_q && hi));

endmodule

// File: rtl/serial_clk_divider.sv
module serial_clk_divider
    import sdiv_pkg::*;
#(
    parameter int MAX_DIV = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] rate_code,
    output logic       div_clk,
    output logic       div_tick,
    output logic [3:0] eff_div
);

    localparam int ABS_MAX = (1 << SD_CODE_W) - 1;

    initial begin
        param_chk: assert (MAX_DIV >= SD_MIN_DIV && MAX_DIV <= ABS_MAX);
    end

    code_t         req_div;
    period_state_t cur;
    period_state_t nxt;
    logic          start_nxt;
    phase_e        phase;
    logic          tick_q;
    logic          bypass_q;

    sdiv_rate_decode #(.MAX_DIV(MAX_DIV)) u_decode (
        .req_code (rate_code),
        .req_div  (req_div)
    );

    sdiv_period_ctr #(.MAX_DIV(MAX_DIV)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .req_div   (req_div),
        .cur       (cur),
        .nxt       (nxt),
        .start_nxt (start_nxt)
    );

    sdiv_phase_gen u_phase (
        .clk       (clk),
        .rst       (rst),
        .nxt       (nxt),
        .start_nxt (start_nxt),
        .phase     (phase),
        .tick_q    (tick_q),
        .bypass_q  (bypass_q)
    );

    assign div_clk  = bypass_q ? clk : (phase == PH_HIGH);
    assign div_tick = tick_q;
    assign eff_div  = cur.div;

    // R4 R5
    fall_point_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(phase == PH_HIGH) |-> (cur.cnt == high_len(cur.div)));

    // R6
    tick_start_chk: assert property (@(posedge clk) disable iff (rst)
        div_tick |-> (cur.run && cur.cnt == '0));

endmodule

// File: tb/test_serial_clk_divider.sv
module test_serial_clk_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] rate_code = 4'd0;
    logic       div_clk;
    logic       div_tick;
    logic [3:0] eff_div;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    serial_clk_divider i_serial_clk_divider (
        .clk       (clk),
        .rst       (rst),
        .rate_code (rate_code),
        .div_clk   (div_clk),
        .div_tick  (div_tick),
        .eff_div   (eff_div)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_div(input int code);
        return (code >= 2 && code <= 10) ? code : 1;
    endfunction

    task automatic find_start(input string req);
        bit hit = 1'b0;
        for (int i = 0; i < 40 && !hit; i++) begin
            @(negedge clk);
            if (div_tick) hit = 1'b1;
        end
        check(hit, req, 0, 1);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(div_clk == 1'b0, "R9 clk low in reset", div_clk, 0);
        check(div_tick == 1'b0, "R9 tick low in reset", div_tick, 0);
        check(eff_div == 4'd0, "R9 eff_div zero in reset", eff_div, 0);
        @(posedge clk); #1;
        check(div_clk == 1'b0, "R9 clk low in reset (clk high)", div_clk, 0);
        @(negedge clk);
        rate_code = 4'd4;
        rst = 1'b0;
        @(negedge clk);
        check(div_tick == 1'b1, "R9 first period after release", div_tick, 1);
        check(eff_div == 4'd4, "R9 first period rate", eff_div, 4);
    endtask

    task automatic t_decode;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            rate_code = 4'(c);
            find_start("R2 period start seen");
            if (c < 2)
                check(int'(eff_div) == exp_div(c), "R1 low code maps to 1", eff_div, exp_div(c));
            else if (c > 10)
                check(int'(eff_div) == exp_div(c), "R3 high code maps to 1", eff_div, exp_div(c));
            else
                check(int'(eff_div) == exp_div(c), "R2 code maps to ratio", eff_div, exp_div(c));
        end
    endtask

    task automatic t_shape(input int n);
        int hi_n;
        string tag;
        hi_n = (n + 1) / 2;
        tag  = (n % 2 == 0) ? "R4 even phase" : "R5 odd phase";
        @(negedge clk);
        rate_code = 4'(n);
        find_start("R6 start of shaped period");
        for (int i = 0; i < n; i++) begin
            check(div_clk == (i < hi_n), tag, div_clk, (i < hi_n));
            check(div_tick == (i == 0), "R6 tick only at start", div_tick, (i == 0));
            @(negedge clk);
        end
        check(div_tick == 1'b1, "R6 period length", div_tick, 1);
        check(int'(eff_div) == n, "R2 ratio in force", eff_div, n);
    endtask

    task automatic t_bypass(input int code);
        @(negedge clk);
        rate_code = 4'(code);
        find_start("R7 bypass start");
        for (int i = 0; i < 4; i++) begin
            check(div_tick == 1'b1, "R7 tick every cycle", div_tick, 1);
            check(div_clk == 1'b0, "R7 follows clk low", div_clk, 0);
            @(posedge clk); #1;
            check(div_clk == 1'b1, "R7 follows clk high", div_clk, 1);
            @(negedge clk);
        end
    endtask

    task automatic t_change;
        @(negedge clk);
        rate_code = 4'd8;
        find_start("R8 old period start");
        @(negedge clk);
        @(negedge clk);
        rate_code = 4'd3;
        for (int i = 2; i < 8; i++) begin
            check(div_clk == (i < 4), "R8 old period unshortened", div_clk, (i < 4));
            check(div_tick == 1'b0, "R8 no early tick", div_tick, 0);
            check(eff_div == 4'd8, "R8 eff_div held", eff_div, 8);
            @(negedge clk);
        end
        check(div_tick == 1'b1, "R8 new period on boundary", div_tick, 1);
        check(eff_div == 4'd3, "R8 new ratio taken", eff_div, 3);
        for (int i = 0; i < 3; i++) begin
            check(div_clk == (i < 2), "R8 new ratio shape", div_clk, (i < 2));
            @(negedge clk);
        end
        check(div_tick == 1'b1, "R8 new period length", div_tick, 1);
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        rate_code = 4'd5;
        find_start("R9 running before reset");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(div_clk == 1'b0, "R9 mid-run reset clk", div_clk, 0);
        check(div_tick == 1'b0, "R9 mid-run reset tick", div_tick, 0);
        check(eff_div == 4'd0, "R9 mid-run reset eff_div", eff_div, 0);
        rst = 1'b0;
        @(negedge clk);
        check(div_tick == 1'b1, "R9 restart tick", div_tick, 1);
        check(eff_div == 4'd5, "R9 restart ratio", eff_div, 5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_decode();
        t_shape(2);
        t_shape(3);
        t_shape(4);
        t_shape(5);
        t_shape(9);
        t_shape(10);
        t_bypass(1);
        t_bypass(14);
        t_change();
        t_reset_mid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule